// File: doc/BRIEF.md
# Pointer Masking Control Registers

This block is the slice of a core's CSR file that owns the pointer-masking state. It stores one small control word shared by all privilege levels, plus a mask and a base register for each of machine, supervisor and user mode. The control word is reachable through three windows: the machine window sees all of it, the supervisor window a subset, and the user window only the user bits. Each write through a narrower window leaves the bits outside that window untouched.

Writes are gated by privilege. A more privileged accessor can always write a lower level's registers. Machine mode can write everything. A supervisor or user routine writing its own level's registers succeeds only while that level's "current" bit is set; otherwise the write is dropped without a trap. Each accepted write marks the extension state dirty and pulses a signal that the core's status register uses to set its extension-dirty and summary-dirty flags. The block also drives the enable, mask and base for the privilege level now running, for use by the load/store address path.

Top module: `ptrmask_csr_bank`

## Requirements
- R1: The nine registers sit at 0x7C0/0x7C1/0x7C2 (machine control/mask/base), 0x9C0/0x9C1/0x9C2 (supervisor) and 0x8C0/0x8C1/0x8C2 (user). The level of a register is CSR address bits [9:8] (3 machine, 1 supervisor, 0 user). Any other address reads 0, never flags illegal and changes nothing.
- R2: Control word layout: bits[1:0] extension state, bit 2 user enable, bit 3 user current, bit 4 supervisor enable, bit 5 supervisor current, bit 6 machine enable. The machine window reads and writes bits 6:0.
- R3: Out of reset the control word is 0x01 (state initial, all enable and current bits 0), and every mask and base register is 0.
- R4: The state encoding is 0 disabled, 1 initial, 2 clean, 3 dirty. Any accepted write to any of the nine registers leaves the state at 3 from the next cycle, whatever data was written.
- R5: dirty_set_o is high in exactly the cycle in which a write is accepted.
- R6: The supervisor window reads bits 5:0 (bit 6 reads 0). A write through it updates bits 5:2 and keeps bit 6.
- R7: The user window reads bits 3:2 in place, with all other bits 0. A write through it changes only bits 3:2.
- R8: Control word bits above bit 6 read as 0 in every window, whatever value was written.
- R9: Privilege encoding is 0 user, 1 supervisor, 3 machine. A write is accepted when the writer is machine, or ranks above the register's level, or is at the register's level with that level's current bit set (bit 5 for supervisor, bit 3 for user). Any other write, including one from below the register's level or from the reserved privilege 2, is dropped with no illegal flag and no dirty pulse.
- R10: While ext_present_i is low, any access to the nine registers flags illegal_o, reads 0 and changes nothing.
- R11: When the supervisor (user) level is configured absent, its three registers flag illegal_o.
- R12: Mask and base registers read back the stored value. Reads have no side effect on any register and raise no dirty pulse.
- R13: pm_enable_o, pm_mask_o and pm_base_o give the running level's enable bit (user bit 2, supervisor bit 4, machine bit 6) and its mask and base. Privilege 2 gives all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_present_i | input | 1 | Strap: pointer masking implemented |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | Write data |
| csr_we_i | input | 1 | Write request |
| cur_priv_i | input | 2 | Privilege of the accessor / running code |
| csr_rdata_o | output | XLEN | Read data for csr_addr_i |
| illegal_o | output | 1 | Access must raise illegal instruction |
| dirty_set_o | output | 1 | Accepted write; set status dirty flags |
| pm_enable_o | output | 1 | Masking enable of the running level |
| pm_mask_o | output | XLEN | Mask of the running level |
| pm_base_o | output | XLEN | Base of the running level |

## Verification
Corruption in the shared control word shows at the ports in two ways. One is the next read through any of the three windows. The other is the enable output, which changes in the cycle after the bad update, since that output is taken straight from the stored bits. A wrong permission decision shows in the same cycle as a wrong dirty_set_o value, and it shows one cycle later as a changed or unchanged read-back of the targeted register. A lost or misdirected mask or base write is seen on the next read, or on the address-path outputs as soon as the running privilege selects that level.

// File: rtl/ptrmask_pkg.sv
package ptrmask_pkg;

   typedef enum logic [1:0] {
      PRIV_U    = 2'b00,
      PRIV_S    = 2'b01,
      PRIV_RSVD = 2'b10,
      PRIV_M    = 2'b11
   } priv_e;

   typedef enum logic [1:0] {
      KIND_CTRL = 2'd0,
      KIND_MASK = 2'd1,
      KIND_BASE = 2'd2,
      KIND_NONE = 2'd3
   } kind_e;

   localparam int CTRL_W  = 7;
   localparam int N_LVL   = 3;
   localparam int B_U_EN  = 2;
   localparam int B_U_CUR = 3;
   localparam int B_S_EN  = 4;
   localparam int B_S_CUR = 5;
   localparam int B_M_EN  = 6;

   localparam logic [1:0] ST_INITIAL = 2'b01;
   localparam logic [1:0] ST_DIRTY   = 2'b11;

   // bits of the shared word visible through each window
   function automatic logic [CTRL_W-1:0] view_mask(priv_e lvl);
      case (lvl)
         PRIV_M:  return 7'h7F;
         PRIV_S:  return 7'h3F;
         PRIV_U:  return 7'h0C;
         default: return 7'h00;
      endcase
   endfunction

   // storage slot for a level: 0 user, 1 supervisor, 2 machine, 3 none
   function automatic logic [1:0] lvl_slot(priv_e lvl);
      case (lvl)
         PRIV_U:  return 2'd0;
         PRIV_S:  return 2'd1;
         PRIV_M:  return 2'd2;
         default: return 2'd3;
      endcase
   endfunction

endpackage

// File: rtl/ptrmask_decode.sv
module ptrmask_decode
   import ptrmask_pkg::*;
#(
   parameter logic [11:0] M_ADDR = 12'h7C0,
   parameter logic [11:0] S_ADDR = 12'h9C0,
   parameter logic [11:0] U_ADDR = 12'h8C0
) (
   input  logic [11:0] addr_i,
   output logic        hit_o,
   output priv_e       lvl_o,
   output kind_e       kind_o
);

   logic [N_LVL-1:0] match;

   always_comb begin
      match[0] = (addr_i[11:2] == U_ADDR[11:2]);
      match[1] = (addr_i[11:2] == S_ADDR[11:2]);
      match[2] = (addr_i[11:2] == M_ADDR[11:2]);
      hit_o    = (|match) && (addr_i[1:0] != 2'b11);
      lvl_o    = priv_e'(addr_i[9:8]);
      kind_o   = hit_o ? kind_e'(addr_i[1:0]) : KIND_NONE;
   end

endmodule

// File: rtl/ptrmask_gate.sv
module ptrmask_gate
   import ptrmask_pkg::*;
#(
   parameter bit HAS_SMODE = 1'b1,
   parameter bit HAS_UMODE = 1'b1
) (
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  ext_present_i,
   input  logic  hit_i,
   input  logic  we_i,
   input  priv_e reg_lvl_i,
   input  priv_e cur_priv_i,
   input  logic  s_cur_i,
   input  logic  u_cur_i,
   output logic  illegal_o,
   output logic  wr_ok_o
);

   logic lvl_absent;
   logic allowed;

   always_comb begin
      lvl_absent = ((reg_lvl_i == PRIV_S) && !HAS_SMODE) ||
                   ((reg_lvl_i == PRIV_U) && !HAS_UMODE);
      illegal_o  = hit_i && (!ext_present_i || lvl_absent);

      case (cur_priv_i)
         PRIV_M:  allowed = 1'b1;
         PRIV_S:  allowed = (reg_lvl_i == PRIV_U) ||
                            ((reg_lvl_i == PRIV_S) && s_cur_i);
         PRIV_U:  allowed = (reg_lvl_i == PRIV_U) && u_cur_i;
         default: allowed = 1'b0;
      endcase

      wr_ok_o = we_i && hit_i && !illegal_o && allowed;
   end

   assert_user_stays_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cur_priv_i == PRIV_U && reg_lvl_i != PRIV_U) |-> !wr_ok_o);

   assert_absent_ext_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ext_present_i) |-> !wr_ok_o);

endmodule

// File: rtl/ptrmask_ctrl_reg.sv
module ptrmask_ctrl_reg
   import ptrmask_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_ok_i,
   input  kind_e             kind_i,
   input  priv_e             lvl_i,
   input  logic [CTRL_W-1:0] wdata_i,
   output logic [CTRL_W-1:0] ctrl_o
);

   logic [CTRL_W-1:0] ctrl_q;
   logic [CTRL_W-1:0] ctrl_d;
   logic [CTRL_W-1:0] win;

   always_comb begin
      win    = view_mask(lvl_i);
      ctrl_d = ctrl_q;
      if (wr_ok_i) begin
         if (kind_i == KIND_CTRL)
            ctrl_d = (ctrl_q & ~win) | (wdata_i & win);
         ctrl_d[1:0] = ST_DIRTY;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctrl_q <= {{(CTRL_W-2){1'b0}}, ST_INITIAL};
      else         ctrl_q <= ctrl_d;
   end

   assign ctrl_o = ctrl_q;

   assert_dirty_after_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_ok_i |=> (ctrl_q[1:0] == ST_DIRTY));

   assert_menable_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ok_i && lvl_i != PRIV_M) |=> (ctrl_q[B_M_EN] == $past(ctrl_q[B_M_EN])));

   assert_user_window_scope_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ok_i && lvl_i == PRIV_U) |=> (ctrl_q[6:4] == $past(ctrl_q[6:4])));

endmodule

// File: rtl/ptrmask_level_regs.sv
module ptrmask_level_regs
   import ptrmask_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       wr_ok_i,
   input  kind_e                      kind_i,
   input  priv_e                      lvl_i,
   input  logic [XLEN-1:0]            wdata_i,
   output logic [N_LVL-1:0][XLEN-1:0] mask_o,
   output logic [N_LVL-1:0][XLEN-1:0] base_o
);

   logic [1:0] slot;
   assign slot = lvl_slot(lvl_i);

   for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            mask_o[g] <= '0;
            base_o[g] <= '0;
         end else if (wr_ok_i && slot == 2'(g)) begin
            if (kind_i == KIND_MASK) mask_o[g] <= wdata_i;
            if (kind_i == KIND_BASE) base_o[g] <= wdata_i;
         end
      end
   end

   assert_idle_regs_stable_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_ok_i |=> ($stable(mask_o) && $stable(base_o)));

endmodule

// File: rtl/ptrmask_csr_bank.sv
module ptrmask_csr_bank
   import ptrmask_pkg::*;
#(
   parameter int          XLEN      = 64,
   parameter bit          HAS_SMODE = 1'b1,
   parameter bit          HAS_UMODE = 1'b1,
   parameter logic [11:0] M_ADDR    = 12'h7C0,
   parameter logic [11:0] S_ADDR    = 12'h9C0,
   parameter logic [11:0] U_ADDR    = 12'h8C0
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            ext_present_i,
   input  logic [11:0]     csr_addr_i,
   input  logic [XLEN-1:0] csr_wdata_i,
   input  logic            csr_we_i,
   input  logic [1:0]      cur_priv_i,
   output logic [XLEN-1:0] csr_rdata_o,
   output logic            illegal_o,
   output logic            dirty_set_o,
   output logic            pm_enable_o,
   output logic [XLEN-1:0] pm_mask_o,
   output logic [XLEN-1:0] pm_base_o
);

   localparam int PAD_W = XLEN - CTRL_W;

   if (XLEN < 16) begin : g_bad_xlen
      $error("ptrmask_csr_bank: XLEN must be at least 16");
   end
   if (M_ADDR[9:8] != 2'b11 || M_ADDR[1:0] != 2'b00) begin : g_bad_m
      $error("ptrmask_csr_bank: machine window address must carry level 3");
   end
   if (S_ADDR[9:8] != 2'b01 || S_ADDR[1:0] != 2'b00) begin : g_bad_s
      $error("ptrmask_csr_bank: supervisor window address must carry level 1");
   end
   if (U_ADDR[9:8] != 2'b00 || U_ADDR[1:0] != 2'b00) begin : g_bad_u
      $error("ptrmask_csr_bank: user window address must carry level 0");
   end

   priv_e                      cur_priv;
   logic                       hit;
   priv_e                      reg_lvl;
   kind_e                      kind;
   logic                       wr_ok;
   logic [CTRL_W-1:0]          ctrl;
   logic [N_LVL-1:0][XLEN-1:0] mask_q;
   logic [N_LVL-1:0][XLEN-1:0] base_q;
   logic [1:0]                 rd_slot;
   logic [1:0]                 run_slot;

   assign cur_priv = priv_e'(cur_priv_i);

   ptrmask_decode #(.M_ADDR(M_ADDR), .S_ADDR(S_ADDR), .U_ADDR(U_ADDR)) u_decode (
      .addr_i (csr_addr_i),
      .hit_o  (hit),
      .lvl_o  (reg_lvl),
      .kind_o (kind)
   );

   ptrmask_gate #(.HAS_SMODE(HAS_SMODE), .HAS_UMODE(HAS_UMODE)) u_gate (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .ext_present_i (ext_present_i),
      .hit_i         (hit),
      .we_i          (csr_we_i),
      .reg_lvl_i     (reg_lvl),
      .cur_priv_i    (cur_priv),
      .s_cur_i       (ctrl[B_S_CUR]),
      .u_cur_i       (ctrl[B_U_CUR]),
      .illegal_o     (illegal_o),
      .wr_ok_o       (wr_ok)
   );

   ptrmask_ctrl_reg u_ctrl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_ok_i (wr_ok),
      .kind_i  (kind),
      .lvl_i   (reg_lvl),
      .wdata_i (csr_wdata_i[CTRL_W-1:0]),
      .ctrl_o  (ctrl)
   );

   ptrmask_level_regs #(.XLEN(XLEN)) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_ok_i (wr_ok),
      .kind_i  (kind),
      .lvl_i   (reg_lvl),
      .wdata_i (csr_wdata_i),
      .mask_o  (mask_q),
      .base_o  (base_q)
   );

   assign dirty_set_o = wr_ok;

   // read mux
   always_comb begin
      rd_slot     = lvl_slot(reg_lvl);
      csr_rdata_o = '0;
      if (hit && !illegal_o && rd_slot != 2'd3) begin
         case (kind)
            KIND_CTRL: csr_rdata_o = {{PAD_W{1'b0}}, ctrl & view_mask(reg_lvl)};
            KIND_MASK: csr_rdata_o = mask_q[rd_slot];
            KIND_BASE: csr_rdata_o = base_q[rd_slot];
            default:   csr_rdata_o = '0;
         endcase
      end
   end

   // address-path selection for the running level
   always_comb begin
      run_slot    = lvl_slot(cur_priv);
      pm_enable_o = 1'b0;
      pm_mask_o   = '0;
      pm_base_o   = '0;
      if (run_slot != 2'd3) begin
         pm_mask_o = mask_q[run_slot];
         pm_base_o = base_q[run_slot];
      end
      case (cur_priv)
         PRIV_U:  pm_enable_o = ctrl[B_U_EN];
         PRIV_S:  pm_enable_o = ctrl[B_S_EN];
         PRIV_M:  pm_enable_o = ctrl[B_M_EN];
         default: pm_enable_o = 1'b0;
      endcase
   end

   assert_unmapped_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit |-> (csr_rdata_o == '0 && !illegal_o && !dirty_set_o));

   assert_rsvd_bits_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && kind == KIND_CTRL) |-> (csr_rdata_o[XLEN-1:CTRL_W] == '0));

   assert_own_level_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csr_we_i && hit && cur_priv == PRIV_S && reg_lvl == PRIV_S && !ctrl[B_S_CUR])
      |-> !dirty_set_o);

   assert_illegal_no_dirty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      illegal_o |-> (!dirty_set_o && csr_rdata_o == '0));

   assert_dirty_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !csr_we_i |-> !dirty_set_o);

endmodule

// File: tb/ptrmask_csr_bank_test.sv
`timescale 1ns/1ps
module ptrmask_csr_bank_test;

   localparam int XLEN = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ext_present = 1'b1;
   logic [11:0]     addr = 12'h000;
   logic [XLEN-1:0] wdata = '0;
   logic            we = 1'b0;
   logic [1:0]      priv = 2'b11;

   logic [XLEN-1:0] rdata, pm_mask, pm_base, rdata_min, mask_min, base_min;
   logic            illegal, dirty_set, pm_en, illegal_min, dirty_min, en_min;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ptrmask_csr_bank #(.XLEN(XLEN)) uut (
      .clk_i(clk), .rst_ni(rst_n), .ext_present_i(ext_present),
      .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_we_i(we), .cur_priv_i(priv),
      .csr_rdata_o(rdata), .illegal_o(illegal), .dirty_set_o(dirty_set),
      .pm_enable_o(pm_en), .pm_mask_o(pm_mask), .pm_base_o(pm_base)
   );

   ptrmask_csr_bank #(.XLEN(XLEN), .HAS_SMODE(1'b0), .HAS_UMODE(1'b0)) uut_min (
      .clk_i(clk), .rst_ni(rst_n), .ext_present_i(ext_present),
      .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_we_i(we), .cur_priv_i(priv),
      .csr_rdata_o(rdata_min), .illegal_o(illegal_min), .dirty_set_o(dirty_min),
      .pm_enable_o(en_min), .pm_mask_o(mask_min), .pm_base_o(base_min)
   );

   task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // write with checks of the same-cycle flags
   task automatic wr(input logic [1:0] p, input logic [11:0] a, input logic [XLEN-1:0] d,
                     input logic exp_dirty, input string req);
      @(negedge clk);
      priv = p; addr = a; wdata = d; we = 1'b1;
      #1;
      chk({req, " dirty_set"}, {63'd0, dirty_set}, {63'd0, exp_dirty});
      chk({req, " illegal"}, {63'd0, illegal}, 64'd0);
      @(negedge clk);
      we = 1'b0; addr = 12'h000; wdata = '0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [XLEN-1:0] exp, input string req);
      @(negedge clk);
      priv = 2'b11; addr = a; we = 1'b0;
      #1;
      chk(req, rdata, exp);
      chk({req, " no dirty on read"}, {63'd0, dirty_set}, 64'd0);
   endtask

   task automatic t_reset();
      rd(12'h7C0, 64'h01, "R3 ctrl reset");
      rd(12'h7C1, 64'h0, "R3 mask reset");
      rd(12'h9C2, 64'h0, "R3 base reset");
      rd(12'h7C0, 64'h01, "R12 reads leave state initial");
   endtask

   task automatic t_windows();
      wr(2'b11, 12'h7C1, 64'h0000_0000_FFFF_0000, 1'b1, "R5 mask write");
      rd(12'h7C0, 64'h03, "R4 mask write sets dirty");
      rd(12'h7C1, 64'h0000_0000_FFFF_0000, "R12 mask readback");
      wr(2'b11, 12'h7C0, 64'hFFFF_FFFF_FFFF_FF54, 1'b1, "R2 machine ctrl write");
      rd(12'h7C0, 64'h57, "R2 R8 machine window");
      rd(12'h9C0, 64'h17, "R6 supervisor window read");
      rd(12'h8C0, 64'h04, "R7 user window read");
      wr(2'b11, 12'h9C0, 64'h28, 1'b1, "R6 supervisor window write");
      rd(12'h7C0, 64'h6B, "R6 bit6 kept");
      wr(2'b11, 12'h8C0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R7 user window write");
      rd(12'h7C0, 64'h6F, "R7 only bits 3:2 change");
   endtask

   task automatic t_permission();
      wr(2'b01, 12'h9C1, 64'hAAAA, 1'b1, "R9 S own level current set");
      rd(12'h9C1, 64'hAAAA, "R9 S mask stored");
      wr(2'b00, 12'h8C2, 64'h1234, 1'b1, "R9 U own level current set");
      wr(2'b01, 12'h8C1, 64'h00FF, 1'b1, "R9 S above U");
      wr(2'b00, 12'h9C1, 64'h5555, 1'b0, "R9 U below S dropped");
      rd(12'h9C1, 64'hAAAA, "R9 S mask unchanged");
      wr(2'b00, 12'h7C2, 64'h7777, 1'b0, "R9 U below M dropped");
      rd(12'h7C2, 64'h0, "R9 M base unchanged");
      wr(2'b11, 12'h7C0, 64'h40, 1'b1, "R9 M clears current bits");
      rd(12'h7C0, 64'h43, "R9 ctrl after clear");
      wr(2'b01, 12'h9C1, 64'h7777, 1'b0, "R9 S own level no current");
      rd(12'h9C1, 64'hAAAA, "R9 S mask kept");
      wr(2'b00, 12'h8C2, 64'h9999, 1'b0, "R9 U own level no current");
      rd(12'h8C2, 64'h1234, "R9 U base kept");
      wr(2'b01, 12'h9C0, 64'h3C, 1'b0, "R9 S ctrl no current");
      rd(12'h7C0, 64'h43, "R9 ctrl kept");
      wr(2'b10, 12'h8C1, 64'h1, 1'b0, "R9 reserved privilege dropped");
      wr(2'b11, 12'h7C0, 64'h20, 1'b1, "R9 M sets S current");
      wr(2'b01, 12'h9C0, 64'h3C, 1'b1, "R9 S ctrl with current");
      rd(12'h7C0, 64'h3F, "R6 R9 S window update");
      wr(2'b00, 12'h8C0, 64'h0, 1'b1, "R9 U ctrl with current");
      rd(12'h7C0, 64'h33, "R7 user clears own bits");
   endtask

   task automatic t_addr_path();
      @(negedge clk); addr = 12'h000; priv = 2'b01; #1;
      chk("R13 S enable", {63'd0, pm_en}, 64'd1);
      chk("R13 S mask", pm_mask, 64'hAAAA);
      chk("R13 S base", pm_base, 64'h0);
      @(negedge clk); priv = 2'b00; #1;
      chk("R13 U enable", {63'd0, pm_en}, 64'd0);
      chk("R13 U mask", pm_mask, 64'h00FF);
      chk("R13 U base", pm_base, 64'h1234);
      @(negedge clk); priv = 2'b11; #1;
      chk("R13 M enable off", {63'd0, pm_en}, 64'd0);
      chk("R13 M mask", pm_mask, 64'h0000_0000_FFFF_0000);
      wr(2'b11, 12'h7C0, 64'h40, 1'b1, "R13 set M enable");
      @(negedge clk); priv = 2'b11; #1;
      chk("R13 M enable on", {63'd0, pm_en}, 64'd1);
      @(negedge clk); priv = 2'b10; #1;
      chk("R13 rsvd enable", {63'd0, pm_en}, 64'd0);
      chk("R13 rsvd mask", pm_mask, 64'h0);
      chk("R13 rsvd base", pm_base, 64'h0);
   endtask

   task automatic t_no_ext();
      @(negedge clk);
      ext_present = 1'b0; priv = 2'b11; addr = 12'h7C1; wdata = 64'hDEAD; we = 1'b1;
      #1;
      chk("R10 illegal when absent", {63'd0, illegal}, 64'd1);
      chk("R10 no dirty when absent", {63'd0, dirty_set}, 64'd0);
      chk("R10 read zero when absent", rdata, 64'h0);
      @(negedge clk);
      we = 1'b0; ext_present = 1'b1; addr = 12'h000;
      rd(12'h7C1, 64'h0000_0000_FFFF_0000, "R10 mask unchanged");
   endtask

   task automatic t_unmapped();
      @(negedge clk);
      priv = 2'b11; addr = 12'h7C3; wdata = 64'hFF; we = 1'b1;
      #1;
      chk("R1 unmapped not illegal", {63'd0, illegal}, 64'd0);
      chk("R1 unmapped no dirty", {63'd0, dirty_set}, 64'd0);
      chk("R1 unmapped reads zero", rdata, 64'h0);
      @(negedge clk);
      we = 1'b0;
      rd(12'hBC1, 64'h0, "R1 foreign address reads zero");
      rd(12'h7C0, 64'h43, "R1 ctrl untouched by unmapped write");
   endtask

   task automatic t_absent_levels();
      @(negedge clk); priv = 2'b11; addr = 12'h9C1; #1;
      chk("R11 S regs illegal when S absent", {63'd0, illegal_min}, 64'd1);
      chk("R11 S regs legal when S present", {63'd0, illegal}, 64'd0);
      @(negedge clk); addr = 12'h8C0; #1;
      chk("R11 U regs illegal when U absent", {63'd0, illegal_min}, 64'd1);
      @(negedge clk); addr = 12'h7C2; #1;
      chk("R11 M regs still legal", {63'd0, illegal_min}, 64'd0);
      @(negedge clk); addr = 12'h000;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_windows();
      t_permission();
      t_addr_path();
      t_no_ext();
      t_unmapped();
      t_absent_levels();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      #50000;
      if (!done) begin
         done = 1'b1;
         vectors++;
         miscompares++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule